// File: doc/BRIEF.md
# Reloadable Underflow Timer Channel

A single 32-bit down-counting timer channel. It decrements only in cycles where an externally generated prescaler tick is high, so the counting rate is set outside the block. Software-style access goes through a small write/read port. A 2-bit select picks one of three registers: the live count, the reload value, or a control/status word.

The channel expires when the count underflows past zero, not when it reaches zero. A value N placed in the counter therefore needs N+1 ticks before it expires. On expiry the channel can raise a one-cycle interrupt pulse and set a sticky pending flag. It then either refills the counter from the reload register and keeps counting, or parks at zero and stops until it is started again. The control word also carries a self-clearing load strobe, a write-one-to-clear pending flag, and two unimplemented bits that have no effect on counting.

Top module: `uflow_timer_chan`

## Requirements
- R1: After reset, the counter, the reload value and the control word all read as zero, and `irqPulse` is low.
- R2: The counter changes only in cycles where `tick` is high and the channel is enabled (control bit 0) and started. With `tick` low or enable clear, the count holds.
- R3: A started channel holding N expires on the (N+1)-th tick. After N ticks the count reads 0 and no pulse has occurred.
- R4: On expiry with interrupt enable (control bit 3) set, control bit 4 (pending) becomes 1 and `irqPulse` is high for exactly the one cycle following the expiring tick edge.
- R5: Pending clears only on a control write with bit 4 at one. A control write with bit 4 at zero leaves pending unchanged.
- R6: On expiry with restart (control bit 1) set, the counter takes the reload value and counting continues, giving one expiry every reload+1 ticks.
- R7: On expiry with restart clear, the counter stays at 0. Further ticks produce no more expiries until the channel is started again.
- R8: A control write with bit 2 (load) set copies the reload value into the counter and starts counting if enable is set. Bit 2 always reads back as 0.
- R9: A write to the counter (select 0) sets the count and starts counting from it if enable is set. With enable clear, the written value holds.
- R10: Control bit 5 (chain) is stored and read back but has no effect. Bit 6 (debug halt) reads as 0 and has no effect. Expiry timing is unchanged with either bit set.
- R11: On expiry with interrupt enable clear, no pulse is produced and pending stays 0.
- R12: In any cycle with `wrEn` high, the counter does not decrement on `tick`. A register write takes that cycle.
- R13: Select 3 reads as zero, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaler tick; one count step per high cycle |
| wrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select: 0 counter, 1 reload, 2 control, 3 none |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data of the selected register |
| irqPulse | output | 1 | One-cycle interrupt pulse on expiry |

## Verification
The assertions assume that `tick`, `wrEn`, `regSel` and the write data carry known values at every sampled edge, and that `regSel` is stable whenever `wrEn` is high. The stimulus keeps within these assumptions. All inputs are driven on the falling clock edge from tasks and are held for a whole cycle. Every write is a single-cycle strobe with the select and data already settled. Outputs are sampled on the falling edge, after the registered pulse and registers have settled.

// File: rtl/uft_pkg.sv
package uft_pkg;
  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_RLD  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  localparam int B_EN    = 0;
  localparam int B_RST   = 1;
  localparam int B_LOAD  = 2;
  localparam int B_IE    = 3;
  localparam int B_PEND  = 4;
  localparam int B_CHAIN = 5;
  localparam int CTRL_IN_W = B_CHAIN + 1;

  typedef struct packed {
    logic writeReload;
    logic loadWrite;
    logic loadReload;
    logic decrement;
  } dpStrobe_t;
endpackage

// File: rtl/uft_datapath.sv
module uft_datapath
  import uft_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpStrobe_t    strobe,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] counterQ,
  output logic [W-1:0] reloadQ,
  output logic         cntZero
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      counterQ <= '0;
      reloadQ  <= '0;
    end else begin
      if (strobe.writeReload) reloadQ <= wrData;
      if (strobe.loadWrite)       counterQ <= wrData;
      else if (strobe.loadReload) counterQ <= reloadQ;
      else if (strobe.decrement)  counterQ <= counterQ - 1'b1;
    end
  end

  assign cntZero = (counterQ == '0);
endmodule

// File: rtl/uft_control.sv
module uft_control
  import uft_pkg::*;
#(
  parameter int W = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic                 wrEn,
  input  logic [1:0]           regSel,
  input  logic [CTRL_IN_W-1:0] ctrlIn,
  input  logic                 cntZero,
  output dpStrobe_t            strobe,
  output logic [W-1:0]         ctrlWord,
  output logic                 irqPulse,
  output logic                 armedQ,
  output logic                 pendingQ,
  output logic                 enableQ,
  output logic                 intEnQ
);
  logic restartQ, chainQ;
  logic ctrlWr, cntWr, rldWr, run, expire;

  assign ctrlWr = wrEn && (regSel == SEL_CTRL);
  assign cntWr  = wrEn && (regSel == SEL_CNT);
  assign rldWr  = wrEn && (regSel == SEL_RLD);
  // a write cycle never counts, so writes and expiry cannot collide
  assign run    = armedQ && enableQ && tick && !wrEn;
  assign expire = run && cntZero;

  always_comb begin
    strobe.writeReload = rldWr;
    strobe.loadWrite   = cntWr;
    strobe.loadReload  = (expire && restartQ) || (ctrlWr && ctrlIn[B_LOAD]);
    strobe.decrement   = run && !cntZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ  <= 1'b0;
      restartQ <= 1'b0;
      intEnQ   <= 1'b0;
      chainQ   <= 1'b0;
      pendingQ <= 1'b0;
      armedQ   <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      irqPulse <= expire && intEnQ;
      if (ctrlWr) begin
        enableQ  <= ctrlIn[B_EN];
        restartQ <= ctrlIn[B_RST];
        intEnQ   <= ctrlIn[B_IE];
        chainQ   <= ctrlIn[B_CHAIN];
        armedQ   <= ctrlIn[B_EN];
        if (ctrlIn[B_PEND]) pendingQ <= 1'b0;
      end else if (cntWr) begin
        armedQ <= enableQ;
      end else if (expire) begin
        armedQ <= restartQ;
        if (intEnQ) pendingQ <= 1'b1;
      end
    end
  end

  always_comb begin
    ctrlWord          = '0;
    ctrlWord[B_EN]    = enableQ;
    ctrlWord[B_RST]   = restartQ;
    ctrlWord[B_IE]    = intEnQ;
    ctrlWord[B_PEND]  = pendingQ;
    ctrlWord[B_CHAIN] = chainQ;
  end
endmodule

// File: rtl/uflow_timer_chan.sv
module uflow_timer_chan
  import uft_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         wrEn,
  input  logic [1:0]   regSel,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         irqPulse
);
  dpStrobe_t    strobe;
  logic [W-1:0] counterQ, reloadQ, ctrlWord;
  logic         cntZero, armedQ, pendingQ, enableQ, intEnQ;

  uft_control #(.W(W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .regSel(regSel),
    .ctrlIn(wrData[CTRL_IN_W-1:0]), .cntZero(cntZero), .strobe(strobe),
    .ctrlWord(ctrlWord), .irqPulse(irqPulse), .armedQ(armedQ),
    .pendingQ(pendingQ), .enableQ(enableQ), .intEnQ(intEnQ)
  );

  uft_datapath #(.W(W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .counterQ(counterQ), .reloadQ(reloadQ), .cntZero(cntZero)
  );

  always_comb begin
    case (regSel)
      SEL_CNT:  rdData = counterQ;
      SEL_RLD:  rdData = reloadQ;
      SEL_CTRL: rdData = ctrlWord;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/uft_checker.sv
module uft_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rstN,
  input logic         tick,
  input logic         wrEn,
  input logic [1:0]   regSel,
  input logic         wrClr,
  input logic         irqPulse,
  input logic [W-1:0] counterQ,
  input logic         pendingQ,
  input logic         armedQ,
  input logic         enableQ,
  input logic         intEnQ
);
  // R2: no tick and no write keeps the count
  a_r2_hold_without_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !wrEn) |=> $stable(counterQ));

  // R3: a running non-zero count steps down by exactly one
  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (!wrEn && tick && enableQ && armedQ && counterQ != '0)
      |=> (counterQ == $past(counterQ) - 1'b1));

  // R4: every pulse comes with pending set
  a_r4_pulse_sets_pending: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> pendingQ);

  // R5: pending only drops on a clearing control write
  a_r5_pending_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !(wrEn && regSel == 2'd2 && wrClr)) |=> pendingQ);

  // R11: a pulse requires interrupt enable in the expiring cycle
  a_r11_masked_no_pulse: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> $past(intEnQ));
endmodule

bind uflow_timer_chan uft_checker #(.W(W)) u_chk (
  .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .regSel(regSel),
  .wrClr(wrData[4]), .irqPulse(irqPulse), .counterQ(counterQ),
  .pendingQ(pendingQ), .armedQ(armedQ), .enableQ(enableQ), .intEnQ(intEnQ)
);

// File: tb/uflow_timer_chan_bench.sv
module uflow_timer_chan_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqPulse;
  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  uflow_timer_chan u_uflow_timer_chan (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .regSel(regSel),
    .wrData(wrData), .rdData(rdData), .irqPulse(irqPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] sel, input logic [31:0] d);
    wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [1:0] sel, output logic [31:0] v);
    regSel = sel;
    #1 v = rdData;
  endtask

  task automatic tickCount(input int n, output int pulses);
    pulses = 0;
    tick = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (irqPulse) pulses++;
    end
    tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    readReg(2'd0, v); check("R1 counter", v, 0);
    readReg(2'd1, v); check("R1 reload", v, 0);
    readReg(2'd2, v); check("R1 control", v, 0);
    check("R1 irq", {31'b0, irqPulse}, 0);
    writeReg(2'd3, 32'hFFFF_FFFF);
    readReg(2'd3, v); check("R13 select 3", v, 0);
    readReg(2'd1, v); check("R13 no side effect", v, 0);
  endtask

  task automatic t_oneshot();
    logic [31:0] v; int p;
    writeReg(2'd1, 32'd3);
    writeReg(2'd2, 32'h0D);
    readReg(2'd2, v); check("R8 load reads zero", v, 32'h09);
    readReg(2'd0, v); check("R8 counter loaded", v, 3);
    repeat (5) @(negedge clk);
    readReg(2'd0, v); check("R2 hold without tick", v, 3);
    tickCount(3, p);
    readReg(2'd0, v); check("R3 count at zero", v, 0);
    check("R3 no early pulse", p, 0);
    tickCount(1, p);
    check("R3 expiry on N+1", p, 1);
    readReg(2'd2, v); check("R4 pending set", v, 32'h19);
    @(negedge clk);
    check("R4 single pulse", {31'b0, irqPulse}, 0);
    tickCount(6, p);
    check("R7 no further expiry", p, 0);
    readReg(2'd0, v); check("R7 counter parked", v, 0);
  endtask

  task automatic t_pending();
    logic [31:0] v;
    writeReg(2'd2, 32'h08);
    readReg(2'd2, v); check("R5 pending kept", v, 32'h18);
    writeReg(2'd2, 32'h18);
    readReg(2'd2, v); check("R5 pending cleared", v, 32'h08);
  endtask

  task automatic t_restart();
    logic [31:0] v; int p;
    writeReg(2'd1, 32'd2);
    writeReg(2'd2, 32'h0F);
    tickCount(3, p);
    check("R6 first period", p, 1);
    readReg(2'd0, v); check("R6 reloaded", v, 2);
    tickCount(3, p);
    check("R6 second period", p, 1);
    tickCount(2, p);
    readReg(2'd0, v); check("R6 keeps counting", v, 0);
    writeReg(2'd2, 32'h10);
  endtask

  task automatic t_masked();
    logic [31:0] v; int p;
    writeReg(2'd1, 32'd1);
    writeReg(2'd2, 32'h05);
    tickCount(4, p);
    check("R11 no pulse", p, 0);
    readReg(2'd2, v); check("R11 no pending", v, 32'h01);
  endtask

  task automatic t_direct();
    logic [31:0] v; int p;
    writeReg(2'd2, 32'h01);
    writeReg(2'd0, 32'd5);
    tickCount(2, p);
    readReg(2'd0, v); check("R9 counts from written", v, 3);
    writeReg(2'd2, 32'h00);
    writeReg(2'd0, 32'd7);
    tickCount(3, p);
    readReg(2'd0, v); check("R9 disabled holds", v, 7);
  endtask

  task automatic t_writeWins();
    logic [31:0] v;
    writeReg(2'd2, 32'h01);
    tick = 1'b1;
    writeReg(2'd1, 32'd9);
    tick = 1'b0;
    readReg(2'd0, v); check("R12 write cycle no step", v, 7);
    writeReg(2'd2, 32'h00);
  endtask

  task automatic t_chainDebug();
    logic [31:0] v; int p;
    writeReg(2'd1, 32'd2);
    writeReg(2'd2, 32'h6D);
    readReg(2'd2, v); check("R10 readback", v, 32'h29);
    tickCount(2, p);
    check("R10 no early pulse", p, 0);
    tickCount(1, p);
    check("R10 timing unchanged", p, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_oneshot();
    t_pending();
    t_restart();
    t_masked();
    t_direct();
    t_writeWins();
    t_chainDebug();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end
endmodule